// File: doc/BRIEF.md
# D4 Remote-Alarm (Yellow) Integrator

This block watches a D4-framed T1 receive stream for the far end's remote-alarm indication. An upstream framer supplies one strobe per DS0 channel with that channel's second bit, one strobe per frame, and one strobe per superframe with the S-bit taken from frame 12. The block counts how many of the channel bits are ones over each integration period of 48 ms, which is 384 frames. A period with few enough ones counts as a yellow period. The count tolerates a small number of ones, so that line errors do not hide the alarm.

There are three outputs. A sampled alarm is refreshed once at each period boundary with the verdict for that period alone. An integrated alarm sets only after a run of yellow periods that covers about 600 ms, and clears after a run of clean periods that covers about 200 ms. A separate secondary alarm follows the frame-12 S-bit and is raised when two consecutive superframes carry a one there. The block assumes that frame and superframe alignment are already established upstream.

Top module: `d4_remote_alarm`

## Requirements
- R1: While reset is held, and on the first cycle after reset, all three alarm outputs are low.
- R2: An integration period spans FRAMES_PER_PERIOD cycles with `frame_tick` high. The first period starts at reset. Only cycles with `chan_bit_vld` high contribute, and each such cycle with `chan_bit` = 1 adds one to the count. A one on `chan_bit` while `chan_bit_vld` is low is ignored.
- R3: `alarm_sample` changes only in the cycle after the frame tick that closes a period. In that cycle it takes the value 1 if the period was yellow and 0 if it was not, and it holds that value for the whole of the next period.
- R4: A period is yellow when its count of ones is at most ONES_LIMIT (default 16). A period with exactly ONES_LIMIT ones is yellow, and a period with ONES_LIMIT+1 ones is not. A channel bit strobed in the same cycle as the closing frame tick belongs to the period that is closing.
- R5: `alarm_integ` rises in the cycle after the close of the SET_PERIODS-th consecutive yellow period (default 13, about 600 ms).
- R6: A period that is not yellow restarts the count of consecutive yellow periods from zero.
- R7: `alarm_integ` falls in the cycle after the close of the CLEAR_PERIODS-th consecutive period that is not yellow (default 4, about 200 ms). A yellow period restarts that count from zero.
- R8: `alarm_sec` rises in the cycle after an S-bit strobe with value 1 when the previous S-bit strobe also carried 1. After reset, the previous S-bit value is taken as 0.
- R9: `alarm_sec` falls in the cycle after an S-bit strobe with value 0.
- R10: `sbit_val` is ignored while `sbit_vld` is low. It neither changes `alarm_sec` nor replaces the stored previous S-bit. S-bit activity has no effect on the other two outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chan_bit_vld | input | 1 | Strobe: a DS0 channel's second bit is present |
| chan_bit | input | 1 | Value of that channel bit |
| sbit_vld | input | 1 | Strobe: the frame-12 S-bit is present |
| sbit_val | input | 1 | Value of the frame-12 S-bit |
| frame_tick | input | 1 | One pulse per received frame |
| alarm_sample | output | 1 | Yellow verdict of the last completed period |
| alarm_integ | output | 1 | Debounced remote alarm |
| alarm_sec | output | 1 | Secondary yellow alarm from the S-bit |

## Verification
A wrong frame counter or a wrong ones counter moves or corrupts the period verdict. The first place this shows is `alarm_sample`, at the next period boundary, and the count sweep that crosses ONES_LIMIT catches it there. An error in a run counter shows only in `alarm_integ`, and only after a whole sequence of periods. For that reason, verdict runs are broken at every depth short of the set and clear thresholds, so that an early or late edge is seen at the boundary where it occurs. A bad stored S-bit shows at the very next S-bit strobe.

// File: rtl/d4ya_pkg.sv
// Shared types for the D4 remote-alarm integrator.
package d4ya_pkg;

    // Verdict of one integration period, valid while done is high
    typedef struct packed {
        logic done;
        logic yellow;
    } period_verdict_t;

endpackage

// File: rtl/d4ya_period_counter.sv
// Integration-period counter.
// Counts frame ticks into periods of FRAMES_PER_PERIOD frames and counts the
// strobed channel bits that are ones, saturating at ONES_LIMIT+1. On the
// closing tick it issues a verdict and registers the sampled alarm.
// Assumes frame_tick is already aligned to frame boundaries upstream.
module d4ya_period_counter
    import d4ya_pkg::*;
#(
    parameter int FRAMES_PER_PERIOD = 384,
    parameter int ONES_LIMIT        = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_tick,
    input  logic            chan_bit_vld,
    input  logic            chan_bit,
    output period_verdict_t verdict,
    output logic            alarm_sample
);
    localparam int FC_W   = (FRAMES_PER_PERIOD > 2) ? $clog2(FRAMES_PER_PERIOD) : 1;
    localparam int ONES_W = $clog2(ONES_LIMIT + 2);
    localparam logic [ONES_W-1:0] ONES_SAT  = ONES_W'(ONES_LIMIT + 1);
    localparam logic [ONES_W-1:0] ONES_MAX  = ONES_W'(ONES_LIMIT);
    localparam logic [FC_W-1:0]   LAST_FRM  = FC_W'(FRAMES_PER_PERIOD - 1);

    logic [FC_W-1:0]   frame_cnt;
    logic [ONES_W-1:0] ones_cnt;
    logic [ONES_W-1:0] ones_next;
    logic              period_end;
    logic              yellow_now;

    // Next ones count including this cycle's strobed bit, saturating
    always_comb begin
        ones_next = ones_cnt;
        if (chan_bit_vld && chan_bit && (ones_cnt != ONES_SAT))
            ones_next = ones_cnt + 1'b1;
    end

    // Period close and its verdict
    always_comb begin
        period_end     = frame_tick && (frame_cnt == LAST_FRM);
        yellow_now     = (ones_next <= ONES_MAX);
        verdict.done   = period_end;
        verdict.yellow = yellow_now;
    end

    // Frame position within the period
    always_ff @(posedge clk) begin
        if (!rst_n)
            frame_cnt <= '0;
        else if (period_end)
            frame_cnt <= '0;
        else if (frame_tick)
            frame_cnt <= frame_cnt + 1'b1;
    end

    // Ones accumulation, restarted at each period close
    always_ff @(posedge clk) begin
        if (!rst_n)
            ones_cnt <= '0;
        else if (period_end)
            ones_cnt <= '0;
        else
            ones_cnt <= ones_next;
    end

    // Sampled alarm refreshed once per period
    always_ff @(posedge clk) begin
        if (!rst_n)
            alarm_sample <= 1'b0;
        else if (period_end)
            alarm_sample <= yellow_now;
    end

    // R2
    ones_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ones_cnt <= ONES_SAT);

    // R3
    sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(alarm_sample) |-> $past(frame_tick));

endmodule

// File: rtl/d4ya_persist.sv
// Persistence filter for the integrated alarm.
// Counts consecutive yellow and consecutive clean period verdicts. It sets the
// alarm on the SET_PERIODS-th yellow period in a row and clears it on the
// CLEAR_PERIODS-th clean period in a row. An opposite verdict restarts a run.
module d4ya_persist
    import d4ya_pkg::*;
#(
    parameter int SET_PERIODS   = 13,
    parameter int CLEAR_PERIODS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  period_verdict_t verdict,
    output logic            alarm_integ
);
    localparam int RUN_MAX = (SET_PERIODS > CLEAR_PERIODS) ? SET_PERIODS : CLEAR_PERIODS;
    localparam int RUN_W   = $clog2(RUN_MAX + 1);
    localparam logic [RUN_W-1:0] SET_LAST = RUN_W'(SET_PERIODS - 1);
    localparam logic [RUN_W-1:0] CLR_LAST = RUN_W'(CLEAR_PERIODS - 1);
    localparam logic [RUN_W-1:0] SET_CAP  = RUN_W'(SET_PERIODS);
    localparam logic [RUN_W-1:0] CLR_CAP  = RUN_W'(CLEAR_PERIODS);

    logic [RUN_W-1:0] set_run;
    logic [RUN_W-1:0] clr_run;
    logic             done_i;
    logic             yellow_i;

    // Unpack the verdict for readability
    always_comb begin
        done_i   = verdict.done;
        yellow_i = verdict.yellow;
    end

    // Run counters and the alarm state, updated at each period close
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_run     <= '0;
            clr_run     <= '0;
            alarm_integ <= 1'b0;
        end else if (done_i) begin
            if (yellow_i) begin
                clr_run <= '0;
                if (set_run < SET_CAP)
                    set_run <= set_run + 1'b1;
                if (set_run >= SET_LAST)
                    alarm_integ <= 1'b1;
            end else begin
                set_run <= '0;
                if (clr_run < CLR_CAP)
                    clr_run <= clr_run + 1'b1;
                if (clr_run >= CLR_LAST)
                    alarm_integ <= 1'b0;
            end
        end
    end

    // R5
    integ_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_integ) |-> $past(done_i && yellow_i));

    // R7
    integ_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm_integ) |-> $past(done_i && !yellow_i));

    // R6
    run_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_run == '0) || (clr_run == '0));

endmodule

// File: rtl/d4ya_sbit_detect.sv
// Secondary yellow detector.
// Keeps the previous frame-12 S-bit value. It raises the alarm when two
// strobed S-bits in a row are ones and drops it on a strobed zero. Values
// presented without a strobe are ignored.
module d4ya_sbit_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sbit_vld,
    input  logic sbit_val,
    output logic alarm_sec
);
    logic sbit_prev;

    // Previous S-bit memory and alarm update on each strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sbit_prev <= 1'b0;
            alarm_sec <= 1'b0;
        end else if (sbit_vld) begin
            sbit_prev <= sbit_val;
            alarm_sec <= sbit_val && sbit_prev;
        end
    end

    // R8
    sec_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_sec) |-> $past(sbit_vld && sbit_val));

    // R10
    sec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sbit_vld |=> $stable(alarm_sec));

endmodule

// File: rtl/d4_remote_alarm.sv
// D4 remote-alarm integrator, top level.
// Joins the period counter, the persistence filter and the S-bit detector.
// Assumes frame alignment, the channel-bit strobes and the frame-12 S-bit
// strobe are provided by an upstream framer.
module d4_remote_alarm
    import d4ya_pkg::*;
#(
    parameter int FRAMES_PER_PERIOD = 384,
    parameter int ONES_LIMIT        = 16,
    parameter int SET_PERIODS       = 13,
    parameter int CLEAR_PERIODS     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chan_bit_vld,
    input  logic chan_bit,
    input  logic sbit_vld,
    input  logic sbit_val,
    input  logic frame_tick,
    output logic alarm_sample,
    output logic alarm_integ,
    output logic alarm_sec
);
    period_verdict_t verdict;

    d4ya_period_counter #(
        .FRAMES_PER_PERIOD(FRAMES_PER_PERIOD),
        .ONES_LIMIT       (ONES_LIMIT)
    ) u_period (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_tick  (frame_tick),
        .chan_bit_vld(chan_bit_vld),
        .chan_bit    (chan_bit),
        .verdict     (verdict),
        .alarm_sample(alarm_sample)
    );

    d4ya_persist #(
        .SET_PERIODS  (SET_PERIODS),
        .CLEAR_PERIODS(CLEAR_PERIODS)
    ) u_persist (
        .clk        (clk),
        .rst_n      (rst_n),
        .verdict    (verdict),
        .alarm_integ(alarm_integ)
    );

    d4ya_sbit_detect u_sbit (
        .clk      (clk),
        .rst_n    (rst_n),
        .sbit_vld (sbit_vld),
        .sbit_val (sbit_val),
        .alarm_sec(alarm_sec)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !alarm_sample && !alarm_integ && !alarm_sec);

endmodule

// File: tb/sim_d4_remote_alarm.sv
`timescale 1ns/1ps
module sim_d4_remote_alarm;
    localparam int FPP   = 4;
    localparam int LIM   = 3;
    localparam int SETP  = 3;
    localparam int CLRP  = 2;
    localparam int CH    = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic chan_bit_vld, chan_bit, sbit_vld, sbit_val, frame_tick;
    logic alarm_sample, alarm_integ, alarm_sec;

    int n_chk = 0;
    int n_bad = 0;

    // model state
    logic exp_sample = 1'b0;
    logic exp_integ  = 1'b0;
    logic exp_sec    = 1'b0;
    logic exp_prev   = 1'b0;
    int   set_run    = 0;
    int   clr_run    = 0;

    always #4 clk = ~clk;

    d4_remote_alarm #(
        .FRAMES_PER_PERIOD(FPP),
        .ONES_LIMIT       (LIM),
        .SET_PERIODS      (SETP),
        .CLEAR_PERIODS    (CLRP)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .chan_bit_vld(chan_bit_vld), .chan_bit(chan_bit),
        .sbit_vld(sbit_vld), .sbit_val(sbit_val), .frame_tick(frame_tick),
        .alarm_sample(alarm_sample), .alarm_integ(alarm_integ), .alarm_sec(alarm_sec)
    );

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0b exp=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        chan_bit_vld = 1'b0; chan_bit = 1'b0;
        sbit_vld = 1'b0; sbit_val = 1'b0; frame_tick = 1'b0;
    endtask

    // One integration period carrying 'ones' ones among FPP*CH strobed bits,
    // plus one unstrobed '1' per frame (R2 ignore case)
    task automatic run_period(int ones);
        for (int f = 0; f < FPP; f++) begin
            @(negedge clk);
            idle_inputs();
            chan_bit = 1'b1;
            if (f == 2) begin
                chk("R3 hold mid-period sample", alarm_sample, exp_sample);
                chk("R5 R7 hold mid-period integ", alarm_integ, exp_integ);
            end
            for (int c = 0; c < CH; c++) begin
                @(negedge clk);
                chan_bit_vld = 1'b1;
                chan_bit     = ((f * CH + c) < ones);
                frame_tick   = (c == CH - 1);
            end
        end
        @(negedge clk);
        idle_inputs();
        // model
        exp_sample = (ones <= LIM);
        if (exp_sample) begin
            clr_run = 0;
            set_run++;
            if (set_run >= SETP) exp_integ = 1'b1;
        end else begin
            set_run = 0;
            clr_run++;
            if (clr_run >= CLRP) exp_integ = 1'b0;
        end
        if (ones == LIM || ones == LIM + 1)
            chk("R4 limit boundary", alarm_sample, exp_sample);
        else
            chk("R2 R3 period verdict", alarm_sample, exp_sample);
        chk("R5 R6 R7 integrated alarm", alarm_integ, exp_integ);
    endtask

    task automatic send_sbit(logic vld, logic val);
        @(negedge clk);
        idle_inputs();
        sbit_vld = vld;
        sbit_val = val;
        @(negedge clk);
        idle_inputs();
        if (vld) begin
            exp_sec  = val && exp_prev;
            exp_prev = val;
            if (val) chk("R8 secondary rise/hold", alarm_sec, exp_sec);
            else     chk("R9 secondary clear", alarm_sec, exp_sec);
        end else begin
            chk("R10 unstrobed S-bit ignored", alarm_sec, exp_sec);
        end
        chk("R10 S-bit leaves sample alone", alarm_sample, exp_sample);
        chk("R10 S-bit leaves integ alone", alarm_integ, exp_integ);
    endtask

    initial begin
        int seq [12] = '{0, 0, 9, 0, 0, 0, 9, 1, 9, 9, 3, 4};
        rst_n = 1'b0;
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset sample", alarm_sample, 1'b0);
        chk("R1 reset integ", alarm_integ, 1'b0);
        chk("R1 reset sec", alarm_sec, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 post-reset sample", alarm_sample, 1'b0);
        chk("R1 post-reset integ", alarm_integ, 1'b0);
        chk("R1 post-reset sec", alarm_sec, 1'b0);

        // sweep of every ones count the period can hold
        for (int n = 0; n <= FPP * CH; n++) run_period(n);
        // run-length patterns around the set and clear thresholds
        for (int i = 0; i < 12; i++) run_period(seq[i]);
        // qualify runs of every length up to the set threshold, each broken
        for (int len = 1; len <= SETP + 1; len++) begin
            for (int k = 0; k < len; k++) run_period(k % (LIM + 1));
            for (int k = 0; k < len && k < CLRP + 1; k++) run_period(LIM + 1 + k);
        end

        // secondary S-bit detector
        send_sbit(1'b1, 1'b1);
        send_sbit(1'b1, 1'b1);
        send_sbit(1'b1, 1'b1);
        send_sbit(1'b1, 1'b0);
        send_sbit(1'b0, 1'b1);
        send_sbit(1'b1, 1'b1);
        send_sbit(1'b1, 1'b1);
        send_sbit(1'b0, 1'b0);
        send_sbit(1'b1, 1'b1);
        send_sbit(1'b1, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule